// File: doc/BRIEF.md
# Host Command Register Commit Unit

This block is the host-facing command register stage of a memory-card host controller. Software fills a small bank of registers through a single-cycle write port: a 32-bit command word, a command argument, a timeout, a card-type word, a block size, a byte count, and three clock-control words (divider, source, enable). Setting the start flag in the command word asks the card-side logic to take a snapshot of those registers. The request is presented as a level `req_o` that holds until the card side returns `ack_i`. At that edge the snapshot is copied into the card-side outputs and the start flag clears.

A normal start copies the six command-group registers. A clock-only start, selected by bit 21 of the command word, copies only the three clock registers and sends no command. While a start is pending, every write to the register bank is discarded and a lock-error interrupt bit is raised. A start that sets both boot-enable and boot-disable is refused and flagged. Completion reported by the card side raises a command-done bit only when a normal command is outstanding. Raw interrupt bits are cleared by writing ones to them.

Top module: `hcmd_commit_unit`

## Requirements
- R1: After reset the command word reads 0x2000_0000 (only bit 29, use-hold, set), `req_o` is low, `irq_raw_o` is 0, and the card-side copy of the command word is 0x2000_0000.
- R2: A write to address 0 with bit 31 set (and no illegal boot combination) is registered at edge N. `req_o` is high after edge N+1 and stays high, with a stable `req_clk_only_o`, until `ack_i` is sampled high.
- R3: At the edge where `ack_i` is sampled with `req_o` high, bit 31 of the command word clears and `req_o` drops.
- R4: A normal take (bit 21 clear) copies addresses 0..5 (command, argument, timeout, card type, block size, byte count) to the card-side outputs and leaves the clock outputs unchanged.
- R5: A clock-only take (bit 21 set) raises `req_clk_only_o` during the request, copies only addresses 6..8 (divider, source, enable), and leaves the command-group outputs unchanged.
- R6: While bit 31 is set, writes to addresses 0..8 leave every register unchanged and set raw interrupt bit 1 (lock error).
- R7: A `done_i` pulse after a normal take sets raw interrupt bit 0 (command done).
- R8: A `done_i` pulse with no normal command outstanding, including after a clock-only take, leaves bit 0 clear.
- R9: A command write with bits 31, 24 (boot enable) and 26 (boot disable) all set stores the word with bit 31 cleared, raises no request, and sets raw interrupt bit 2 (boot error).
- R10: Writing to address 9 clears each raw interrupt bit whose data bit is 1 and leaves the others. A new event in the same cycle wins over the clear.
- R11: Writes to address 9 are accepted while a start is pending and do not count as lock errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address (0 command, 1 argument, 2 timeout, 3 card type, 4 block size, 5 byte count, 6 divider, 7 source, 8 enable, 9 interrupt clear) |
| wr_data_i | input | 32 | Write data |
| cmd_word_o | output | 32 | Host view of the command word |
| req_o | output | 1 | Snapshot request to the card side |
| req_clk_only_o | output | 1 | Pending request is a clock-only update |
| ack_i | input | 1 | Card side accepts the snapshot |
| done_i | input | 1 | Card side completion pulse |
| card_cmd_o | output | 32 | Card-side command word |
| card_arg_o | output | 32 | Card-side argument |
| card_tmout_o | output | 32 | Card-side timeout |
| card_ctype_o | output | 32 | Card-side card type |
| card_blksiz_o | output | 32 | Card-side block size |
| card_bytcnt_o | output | 32 | Card-side byte count |
| card_clkdiv_o | output | 32 | Card-side clock divider |
| card_clksrc_o | output | 32 | Card-side clock source |
| card_clkena_o | output | 32 | Card-side clock enable |
| irq_raw_o | output | 3 | Raw interrupts: bit 0 done, bit 1 lock error, bit 2 boot error |

## Verification
The assertions assume that the card side drives `ack_i` high only while `req_o` is high, and that `done_i` arrives as a single-cycle pulse some time after a take. The bench raises `ack_i` for exactly one cycle, and only after it has seen `req_o` high. It pulses `done_i` only while no request is pending, and it puts all stimulus on the falling edge so that no input changes at a sampling edge.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
    localparam int WORD_W       = 32;
    localparam int NUM_GRP      = 9;
    localparam int GRP_AW       = $clog2(NUM_GRP);
    localparam int LAST_CMD_REG = 5;
    localparam int FIRST_CLK_REG = 6;
    localparam int ADR_IRQ      = 9;
    localparam int START_BIT    = 31;
    localparam int HOLD_BIT     = 29;
    localparam int BOOT_DIS_BIT = 26;
    localparam int BOOT_EN_BIT  = 24;
    localparam int CLK_ONLY_BIT = 21;
    localparam int IRQ_W        = 3;
    localparam int IRQ_DONE     = 0;
    localparam int IRQ_LOCK     = 1;
    localparam int IRQ_BOOT     = 2;

    typedef enum logic {HS_IDLE, HS_REQ} hs_state_e;
endpackage

// File: rtl/hcmd_regs.sv
module hcmd_regs
    import hcmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [WORD_W-1:0]                   wr_data,
    input  logic                                take_i,
    output logic [NUM_GRP-1:0][WORD_W-1:0]      grp_o,
    output logic                                start_o,
    output logic                                lock_err_o,
    output logic                                boot_err_o
);
    typedef struct packed {
        logic [NUM_GRP-1:0][WORD_W-1:0] grp;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  in_grp;
    logic  bad_boot;
    logic [GRP_AW-1:0] idx;

    assign idx      = wr_addr[GRP_AW-1:0];
    assign in_grp   = int'(wr_addr) < NUM_GRP;
    assign bad_boot = wr_data[START_BIT] && wr_data[BOOT_EN_BIT] && wr_data[BOOT_DIS_BIT];

    always_comb begin
        regs_d     = regs_q;
        lock_err_o = 1'b0;
        boot_err_o = 1'b0;
        if (take_i) begin
            regs_d.grp[0][START_BIT] = 1'b0;
        end
        if (wr_en && in_grp) begin
            if (regs_q.grp[0][START_BIT]) begin
                lock_err_o = 1'b1;
            end else if (idx == '0 && bad_boot) begin
                regs_d.grp[0]            = wr_data;
                regs_d.grp[0][START_BIT] = 1'b0;
                boot_err_o               = 1'b1;
            end else begin
                regs_d.grp[idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q                   <= '0;
            regs_q.grp[0][HOLD_BIT]  <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign grp_o   = regs_q.grp;
    assign start_o = regs_q.grp[0][START_BIT];

    assert_boot_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && !start_o && bad_boot) |=> !start_o);

    assert_locked_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_grp && start_o && !take_i) |=> (grp_o == $past(grp_o)));
endmodule

// File: rtl/hcmd_commit.sv
module hcmd_commit
    import hcmd_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [NUM_GRP-1:0][WORD_W-1:0]      grp_i,
    input  logic                                ack_i,
    input  logic                                done_i,
    output logic                                req_o,
    output logic                                clk_only_o,
    output logic                                take_o,
    output logic                                done_evt_o,
    output logic [NUM_GRP-1:0][WORD_W-1:0]      card_o
);
    typedef struct packed {
        hs_state_e                      st;
        logic                           clk_only;
        logic                           busy;
        logic [NUM_GRP-1:0][WORD_W-1:0] shadow;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d       = hs_q;
        take_o     = 1'b0;
        done_evt_o = 1'b0;
        if (done_i && hs_q.busy) begin
            done_evt_o = 1'b1;
            hs_d.busy  = 1'b0;
        end
        case (hs_q.st)
            HS_IDLE: begin
                if (start_i) begin
                    hs_d.st       = HS_REQ;
                    hs_d.clk_only = grp_i[0][CLK_ONLY_BIT];
                end
            end
            HS_REQ: begin
                if (ack_i) begin
                    take_o  = 1'b1;
                    hs_d.st = HS_IDLE;
                    for (int i = 0; i < NUM_GRP; i++) begin
                        if (hs_q.clk_only ? (i >= FIRST_CLK_REG) : (i <= LAST_CMD_REG)) begin
                            hs_d.shadow[i] = grp_i[i];
                        end
                    end
                    if (!hs_q.clk_only) begin
                        hs_d.busy = 1'b1;
                    end
                end
            end
            default: hs_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q                      <= '0;
            hs_q.st                   <= HS_IDLE;
            hs_q.shadow[0][HOLD_BIT]  <= 1'b1;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign req_o      = (hs_q.st == HS_REQ);
    assign clk_only_o = hs_q.clk_only;
    assign card_o     = hs_q.shadow;

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(clk_only_o)));

    assert_req_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !req_o);

    assert_clk_only_keeps_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && clk_only_o) |=> $stable(card_o[0]));

    assert_normal_keeps_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !clk_only_o) |=> $stable(card_o[FIRST_CLK_REG]));
endmodule

// File: rtl/hcmd_irq.sv
module hcmd_irq
    import hcmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [IRQ_W-1:0]  wr_bits,
    input  logic              done_evt_i,
    input  logic              lock_evt_i,
    input  logic              boot_evt_i,
    output logic [IRQ_W-1:0]  raw_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] raw;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [IRQ_W-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[IRQ_DONE] = done_evt_i;
        set_vec[IRQ_LOCK] = lock_evt_i;
        set_vec[IRQ_BOOT] = boot_evt_i;
        irq_d = irq_q;
        if (wr_en && int'(wr_addr) == ADR_IRQ) begin
            irq_d.raw = irq_d.raw & ~wr_bits;
        end
        irq_d.raw = irq_d.raw | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign raw_o = irq_q.raw;

    assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_o[IRQ_DONE]) |-> $past(done_evt_i));

    assert_lock_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_o[IRQ_LOCK]) |-> $past(lock_evt_i));
endmodule

// File: rtl/hcmd_commit_unit.sv
module hcmd_commit_unit
    import hcmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       cmd_word_o,
    output logic              req_o,
    output logic              req_clk_only_o,
    input  logic              ack_i,
    input  logic              done_i,
    output logic [31:0]       card_cmd_o,
    output logic [31:0]       card_arg_o,
    output logic [31:0]       card_tmout_o,
    output logic [31:0]       card_ctype_o,
    output logic [31:0]       card_blksiz_o,
    output logic [31:0]       card_bytcnt_o,
    output logic [31:0]       card_clkdiv_o,
    output logic [31:0]       card_clksrc_o,
    output logic [31:0]       card_clkena_o,
    output logic [2:0]        irq_raw_o
);
    logic [NUM_GRP-1:0][WORD_W-1:0] grp;
    logic [NUM_GRP-1:0][WORD_W-1:0] card;
    logic start, take, lock_evt, boot_evt, done_evt;

    hcmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .take_i(take), .grp_o(grp), .start_o(start),
        .lock_err_o(lock_evt), .boot_err_o(boot_evt)
    );

    hcmd_commit u_commit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .grp_i(grp), .ack_i(ack_i),
        .done_i(done_i), .req_o(req_o), .clk_only_o(req_clk_only_o),
        .take_o(take), .done_evt_o(done_evt), .card_o(card)
    );

    hcmd_irq #(.ADDR_W(ADDR_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_bits(wr_data_i[IRQ_W-1:0]), .done_evt_i(done_evt),
        .lock_evt_i(lock_evt), .boot_evt_i(boot_evt), .raw_o(irq_raw_o)
    );

    assign cmd_word_o    = grp[0];
    assign card_cmd_o    = card[0];
    assign card_arg_o    = card[1];
    assign card_tmout_o  = card[2];
    assign card_ctype_o  = card[3];
    assign card_blksiz_o = card[4];
    assign card_bytcnt_o = card[5];
    assign card_clkdiv_o = card[6];
    assign card_clksrc_o = card[7];
    assign card_clkena_o = card[8];

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !cmd_word_o[START_BIT]);

    assert_req_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> cmd_word_o[START_BIT]);
endmodule

// File: tb/hcmd_commit_unit_test.sv
module hcmd_commit_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ack = 1'b0;
    logic        done = 1'b0;
    logic [31:0] cmd_word, c_cmd, c_arg, c_tmo, c_cty, c_blk, c_byt, c_div, c_src, c_ena;
    logic        req, req_co;
    logic [2:0]  irq;
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hcmd_commit_unit #(.ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .cmd_word_o(cmd_word), .req_o(req),
        .req_clk_only_o(req_co), .ack_i(ack), .done_i(done),
        .card_cmd_o(c_cmd), .card_arg_o(c_arg), .card_tmout_o(c_tmo),
        .card_ctype_o(c_cty), .card_blksiz_o(c_blk), .card_bytcnt_o(c_byt),
        .card_clkdiv_o(c_div), .card_clksrc_o(c_src), .card_clkena_o(c_ena),
        .irq_raw_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic give_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cmd word", cmd_word, 32'h2000_0000);
        check("R1 req", {31'b0, req}, 32'd0);
        check("R1 irq", {29'b0, irq}, 32'd0);
        check("R1 card cmd", c_cmd, 32'h2000_0000);
    endtask

    task automatic t_normal();
        wr(4'd1, 32'hA5A5_0001);
        wr(4'd2, 32'h0000_FFFF);
        wr(4'd3, 32'h0000_0001);
        wr(4'd4, 32'h0000_0200);
        wr(4'd5, 32'h0000_0400);
        wr(4'd6, 32'h0000_0003);
        wr(4'd0, 32'h8000_0251);
        check("R2 start latched", cmd_word, 32'h8000_0251);
        check("R2 req not yet", {31'b0, req}, 32'd0);
        tick();
        check("R2 req high", {31'b0, req}, 32'd1);
        check("R2 kind normal", {31'b0, req_co}, 32'd0);
        tick();
        check("R2 req held", {31'b0, req}, 32'd1);
        wr(4'd1, 32'h0000_DEAD);
        check("R6 lock bit", {29'b0, irq}, 32'd2);
        wr(4'd0, 32'h0000_0000);
        check("R6 cmd kept", cmd_word, 32'h8000_0251);
        wr(4'd9, 32'h0000_0002);
        check("R11 irq write while locked", {29'b0, irq}, 32'd0);
        give_ack();
        check("R3 start cleared", cmd_word, 32'h0000_0251);
        check("R3 req dropped", {31'b0, req}, 32'd0);
        check("R4 card cmd", c_cmd, 32'h8000_0251);
        check("R4 card arg (locked write discarded)", c_arg, 32'hA5A5_0001);
        check("R4 card tmout", c_tmo, 32'h0000_FFFF);
        check("R4 card bytcnt", c_byt, 32'h0000_0400);
        check("R4 clkdiv untouched", c_div, 32'd0);
        pulse_done();
        check("R7 done bit", {29'b0, irq}, 32'd1);
        wr(4'd9, 32'h0000_0001);
        check("R10 done cleared", {29'b0, irq}, 32'd0);
    endtask

    task automatic t_clk_only();
        wr(4'd6, 32'h0000_0005);
        wr(4'd7, 32'h0000_0001);
        wr(4'd8, 32'h0000_0001);
        wr(4'd1, 32'h0000_1234);
        wr(4'd0, 32'h8020_0000);
        tick();
        check("R5 req high", {31'b0, req}, 32'd1);
        check("R5 kind clock-only", {31'b0, req_co}, 32'd1);
        give_ack();
        check("R5 clkdiv copied", c_div, 32'h0000_0005);
        check("R5 clksrc copied", c_src, 32'h0000_0001);
        check("R5 clkena copied", c_ena, 32'h0000_0001);
        check("R5 card cmd kept", c_cmd, 32'h8000_0251);
        check("R5 card arg kept", c_arg, 32'hA5A5_0001);
        pulse_done();
        check("R8 no done after clock-only", {29'b0, irq}, 32'd0);
    endtask

    task automatic t_boot();
        wr(4'd0, 32'h8500_0000);
        check("R9 stored without start", cmd_word, 32'h0500_0000);
        check("R9 boot error bit", {29'b0, irq}, 32'd4);
        tick();
        tick();
        check("R9 no request", {31'b0, req}, 32'd0);
        wr(4'd9, 32'h0000_0002);
        check("R10 other bits kept", {29'b0, irq}, 32'd4);
        wr(4'd9, 32'h0000_0004);
        check("R10 boot bit cleared", {29'b0, irq}, 32'd0);
        pulse_done();
        check("R8 idle done ignored", {29'b0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_normal();
        t_clk_only();
        t_boot();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule